// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for the management register file of an Ethernet PHY. A host controller reaches it through a request channel. Each request carries a 5-bit register number, a read/write flag and 16 bits of write data. Each read returns one 16-bit word on a response channel in the cycle after the request is accepted. The block holds 32 registers of 16 bits. For four register numbers it does not return the stored word. Instead it builds the read value from a link-up input and from the local advertisement word held in register 4. This lets driver software see a PHY that is always negotiated and that agrees with whatever it advertises.

Both channels use valid/ready. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high when no response is pending, or when the pending response is taken in the same cycle. This means a stalled response holds back new requests. A response stays valid, with unchanged data, until `rsp_ready` is high. Writes complete when they are accepted and produce no response. The serial management pin protocol and a real negotiation exchange are not part of this block.

Top module: `phy_mgmt_responder`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1. Every other stored register (all numbers except 1, 5, 17 and 18) reads 0x0000.
- R2: A read of any register other than 1, 5, 17 and 18 returns the word last written to it. If it has not been written, the read returns its reset value.
- R3: After any accepted write, to any register, bit 15 and bit 9 of register 0 read as zero. Its other bits keep the written or stored value.
- R4: Register 1 reads 0x0000 while `link_up` is low. While `link_up` is high it reads 0x782E, which is bits 14, 13, 12, 11, 5, 3, 2 and 1 set.
- R5: Register 5 reads 0x4001 OR (register 4 AND 0x01E0). That is, bit 14 and bit 0 are set, and bits 8:5 are copied from register 4.
- R6: Register 17 always reads 0x8000.
- R7: Register 18 reads 0x0000 while `link_up` is low. Otherwise, bit 10 is set when register 4 has bit 7 or bit 8 set. Bit 11 is set when register 4 has bit 8 or bit 6 set. All other bits are zero.
- R8: Writes to registers 1, 5, 17 and 18 do not change what those registers read back.
- R9: A read accepted at a clock edge raises `rsp_valid` after that edge. `rsp_valid` and `rsp_rdata` then hold until a cycle with `rsp_ready` high. `req_ready` is low while a response is pending and `rsp_ready` is low.
- R10: An accepted write does not raise `rsp_valid`.
- R11: A read value is taken from the `link_up` level and the register contents at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state shown in registers 1 and 18 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes read data |
| rsp_rdata | output | 16 | Read data |

## Verification
The hardest case to reach is a read arriving while an earlier response is still stalled. Here the request must wait without changing the held data, and its value must still come from the register state at its own accepting edge. The bench reaches this by lowering `rsp_ready` for several cycles. During that time it keeps `req_valid` high, changes `link_up` and offers writes to register 4. A reference model tracks acceptance on every clock. Long random runs mix stalls, writes to the synthesised numbers and link toggles.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned MGMT_DATA_W = 16;
  localparam int unsigned MGMT_ADDR_W = 5;

  // register numbers with behaviour of their own
  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_STAT   = 1;
  localparam int unsigned IDX_ID_HI  = 2;
  localparam int unsigned IDX_ID_LO  = 3;
  localparam int unsigned IDX_ADV    = 4;
  localparam int unsigned IDX_LPA    = 5;
  localparam int unsigned IDX_SPEED  = 17;
  localparam int unsigned IDX_DIAG   = 18;

  // control bits that never read back as one
  localparam logic [15:0] CTRL_SELFCLR = 16'h8200;
  localparam logic [15:0] STAT_LINKED  = 16'h782E;
  localparam logic [15:0] LPA_FIXED    = 16'h4001;
  localparam logic [15:0] LPA_ADVMASK  = 16'h01E0;
  localparam logic [15:0] SPEED_FIXED  = 16'h8000;

  function automatic logic [15:0] reg_reset_value(input int unsigned idx);
    case (idx)
      IDX_CTRL:  return 16'h3100;
      IDX_ID_HI: return 16'h0300;
      IDX_ID_LO: return 16'hE400;
      IDX_ADV:   return 16'h01E1;
      default:   return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = MGMT_ADDR_W,
  parameter int unsigned DATA_W = MGMT_DATA_W,
  localparam int unsigned NREGS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] regs_o [NREGS]
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= DATA_W'(reg_reset_value(i));
      end else if (wr_en && wr_addr == ADDR_W'(i)) begin
        if (i == IDX_CTRL) word_q <= wr_data & ~DATA_W'(CTRL_SELFCLR);
        else               word_q <= wr_data;
      end else if (wr_en && i == IDX_CTRL) begin
        word_q <= word_q & ~DATA_W'(CTRL_SELFCLR);
      end
    end
    assign regs_o[i] = word_q;
  end

  // R3: after any write the self-clearing control bits are zero
  assert_ctrl_selfclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_o[IDX_CTRL] & DATA_W'(CTRL_SELFCLR)) == '0);
endmodule

// File: rtl/phy_mgmt_read_view.sv
module phy_mgmt_read_view
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = MGMT_ADDR_W,
  parameter int unsigned DATA_W = MGMT_DATA_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              link_up,
  input  logic [DATA_W-1:0] adv_word,
  input  logic [DATA_W-1:0] stored_word,
  output logic [DATA_W-1:0] view_word
);
  logic adv_100h, adv_100f, adv_10f;
  assign adv_10f  = adv_word[6];
  assign adv_100h = adv_word[7];
  assign adv_100f = adv_word[8];

  always_comb begin
    view_word = stored_word;
    case (addr)
      ADDR_W'(IDX_STAT):  view_word = link_up ? DATA_W'(STAT_LINKED) : '0;
      ADDR_W'(IDX_LPA):   view_word = DATA_W'(LPA_FIXED) | (adv_word & DATA_W'(LPA_ADVMASK));
      ADDR_W'(IDX_SPEED): view_word = DATA_W'(SPEED_FIXED);
      ADDR_W'(IDX_DIAG): begin
        view_word = '0;
        if (link_up) begin
          view_word[10] = adv_100h | adv_100f;
          view_word[11] = adv_100f | adv_10f;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = MGMT_ADDR_W,
  parameter int unsigned DATA_W = MGMT_DATA_W,
  localparam int unsigned NREGS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] regs [NREGS];
  logic [DATA_W-1:0] view_word;
  logic              accept, rd_accept, wr_accept;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_accept = accept && !req_write;
  assign wr_accept = accept && req_write;

  phy_mgmt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_accept), .wr_addr(req_addr),
    .wr_data(req_wdata), .regs_o(regs)
  );

  phy_mgmt_read_view #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_view (
    .addr(req_addr), .link_up(link_up), .adv_word(regs[IDX_ADV]),
    .stored_word(regs[req_addr]), .view_word(view_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (rd_accept) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= view_word;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

  // R9: a stalled response holds its data
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  // R9: an accepted read is answered next cycle
  assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);
  // R10: a write taken from idle gives no response
  assert_write_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && (!rsp_valid || rsp_ready) |=> !rsp_valid);
  // R6: the speed register is fixed
  assert_speed_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && req_addr == ADDR_W'(IDX_SPEED)
    |=> rsp_rdata == DATA_W'(SPEED_FIXED));
  // R4: status is zero for a read taken with the link down
  assert_stat_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && req_addr == ADDR_W'(IDX_STAT) && !link_up
    |=> rsp_rdata == '0);
endmodule

// File: tb/phy_mgmt_responder_test.sv
`timescale 1ns/1ps
module phy_mgmt_responder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference model state
  int mem [32];
  bit exp_v = 0;
  int exp_d = 0;
  string exp_tag = "R9";

  always #10 clk = ~clk;

  phy_mgmt_responder uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  function automatic int model_view(int a, bit lk);
    int adv;
    int r;
    adv = mem[4];
    case (a)
      1:  r = lk ? 'h782E : 0;
      5:  r = 'h4001 | (adv & 'h01E0);
      17: r = 'h8000;
      18: begin
        r = 0;
        if (lk) begin
          if (adv[7] || adv[8]) r = r | 'h0400;
          if (adv[8] || adv[6]) r = r | 'h0800;
        end
      end
      default: r = mem[a];
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mem[i] = 0;
    mem[0] = 'h3100; mem[2] = 'h0300; mem[3] = 'hE400; mem[4] = 'h01E1;
    exp_v = 0;
  endtask

  // one clock: drive, compare present outputs, advance model, clock
  task automatic cyc(bit v, bit w, int a, int d, bit rr, string tag);
    bit acc;
    req_valid = v; req_write = w; req_addr = a[4:0]; req_wdata = d[15:0];
    rsp_ready = rr;
    #1;
    check(rsp_valid == exp_v, "R9 rsp_valid", rsp_valid, exp_v);
    if (exp_v) check(rsp_rdata == exp_d[15:0], exp_tag, rsp_rdata, exp_d);
    check(req_ready == (!exp_v || rr), "R9 req_ready", req_ready, !exp_v || rr);
    acc = v && (!exp_v || rr);
    if (exp_v && rr) exp_v = 0;
    if (acc && !w) begin
      exp_v = 1; exp_d = model_view(a, link_up); exp_tag = tag;
    end
    if (acc && w) begin
      mem[a] = d & 'hFFFF;
      mem[0] = mem[0] & ~'h8200;
    end
    @(posedge clk); #3;
  endtask

  task automatic rd(int a, string tag);
    cyc(1, 0, a, 0, 1, tag);
  endtask
  task automatic wr(int a, int d);
    cyc(1, 1, a, d, 1, "R10");
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 1, "R9");
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    idle();  // reset state: no response pending (R1)

    // R1 reset values
    rd(0, "R1"); rd(2, "R1"); rd(3, "R1"); rd(4, "R1"); rd(6, "R1"); rd(31, "R1");
    idle();
    // R2 stored read-back
    wr(6, 'hA5A5); wr(31, 'h1234); rd(6, "R2"); rd(31, "R2"); rd(16, "R2");
    // R3 self-clear bits
    wr(0, 'hFFFF); rd(0, "R3"); wr(0, 'h3100); wr(7, 'h0001); rd(0, "R3");
    // R4 status with link up and down
    rd(1, "R4"); link_up = 1'b0; rd(1, "R4"); link_up = 1'b1; rd(1, "R4");
    // R5 link partner
    rd(5, "R5"); wr(4, 'h0040); rd(5, "R5");
    // R6
    rd(17, "R6");
    // R7 diagnostics under several advertisements
    wr(4, 'h01E1); rd(18, "R7");
    wr(4, 'h0080); rd(18, "R7");
    wr(4, 'h0040); rd(18, "R7");
    wr(4, 'h0100); rd(18, "R7");
    wr(4, 'h0000); rd(18, "R7");
    wr(4, 'h01E1); link_up = 1'b0; rd(18, "R7"); link_up = 1'b1;
    // R8 writes to synthesised numbers
    wr(1, 'h0000); wr(5, 'hFFFF); wr(17, 'h1234); wr(18, 'hFFFF);
    rd(1, "R8"); rd(5, "R8"); rd(17, "R8"); rd(18, "R8");
    // R9 / R11 back-pressure: stalled response, pending read sees later state
    cyc(1, 0, 6, 0, 0, "R9");
    cyc(1, 1, 4, 'h0100, 0, "R9");
    link_up = 1'b0;
    cyc(1, 1, 4, 'h0100, 0, "R9");
    cyc(1, 0, 18, 0, 1, "R9");
    link_up = 1'b1;
    cyc(1, 0, 18, 0, 0, "R11");
    cyc(0, 0, 0, 0, 0, "R11");
    cyc(1, 1, 4, 'h01E1, 1, "R11");
    rd(18, "R11");
    // R10 write from idle
    idle(); wr(9, 'h00FF); idle(); rd(9, "R2");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int a, d, sel;
      bit v, w, rr;
      sel = $urandom_range(0, 9);
      a = (sel < 3) ? (sel == 0 ? 1 : (sel == 1 ? 18 : 4)) : $urandom_range(0, 31);
      d = $urandom_range(0, 'hFFFF);
      v = ($urandom_range(0, 3) != 0);
      w = ($urandom_range(0, 2) == 0);
      rr = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 15) == 0) link_up = ~link_up;
      cyc(v, w, a, d, rr, "R2/R11 random");
    end
    idle(); idle();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule